// File: doc/BRIEF.md
# Lockable Cache Victim Way Selector

This block chooses which way of an eight-way set-associative cache receives a new line when a set is allocated. For the addressed set it takes the valid bit and the line-lock bit of each way. It also takes two way-lock masks, one for data accesses and one for instruction accesses, and a flag that says which kind of access this is. An empty way that may be used is always filled first. When no such way exists, the block picks a victim by one of two strategies, selected by a single input: round-robin, or pseudo-random.

The decision is combinational from the inputs and the block's own state. That state is a round-robin pointer and a free-running 16-bit LFSR. The surrounding cache pulses an allocation strobe when it commits the chosen way, and the round-robin pointer moves only on that strobe. Because separate masks apply to data and to instruction fills, code and data can be confined to different ways. Locking seven of the eight ways makes the cache direct-mapped for that access type.

Top module: `cache_victim_sel`

## Requirements
- R1: A way may be a victim only when its line-lock bit is 0 and its bit in the active way-lock mask is 0. Bit i of every 8-bit vector refers to way i.
- R2: If any eligible way has its valid bit at 0, the victim is the lowest-numbered such way, whatever the strategy.
- R3: With `strategyRandom`=0 and no eligible invalid way, the victim is the first eligible way found by scanning upward from (pointer+1), wrapping from way 7 to way 0.
- R4: After reset the pointer is 7, so the first round-robin scan starts at way 0. On a clock edge with `allocStrobe`=1 and `noVictim`=0, the pointer takes the value of `victimIdx`. In every other case it holds.
- R5: With `strategyRandom`=1 and no eligible invalid way, the victim is an eligible way. Across 64 consecutive cycles with every way eligible and valid, at least 4 different ways are chosen.
- R6: When no way is eligible, `noVictim`=1, `victimOneHot`=0 and `victimIdx`=0, and an allocation strobe leaves the pointer unchanged.
- R7: When `noVictim`=0, `victimOneHot` has exactly one bit set, at position `victimIdx`.
- R8: When exactly one way is eligible, that way is the victim under both strategies.
- R9: `instrWayLock` is the active mask when `accessInstr`=1, and `dataWayLock` is the active mask when `accessInstr`=0. The inactive mask has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocStrobe | input | 1 | Allocation committed this cycle |
| strategyRandom | input | 1 | 1 selects pseudo-random, 0 selects round-robin |
| accessInstr | input | 1 | 1 for an instruction access, 0 for a data access |
| validBits | input | 8 | Valid bit of each way in the set |
| lineLockBits | input | 8 | Line-lock bit of each way in the set |
| dataWayLock | input | 8 | Way-lock mask for data accesses |
| instrWayLock | input | 8 | Way-lock mask for instruction accesses |
| victimOneHot | output | 8 | Chosen way, one-hot |
| victimIdx | output | 3 | Chosen way, encoded |
| noVictim | output | 1 | No eligible way exists |

## Verification
A pointer that is wrong inside the block shows at the ports on the first round-robin decision made over a full set, in the same cycle the inputs are applied. A skipped or extra update shows one strobe later as a victim offset from the expected sequence. A stuck or constant LFSR shows only over many cycles, as too few distinct random picks, so that check watches a window of 64 cycles. Masking errors show at once as a locked or wrong-type way appearing on `victimOneHot`.

// File: rtl/victim_pkg.sv
package victim_pkg;
  localparam int WAYS  = 8;
  localparam int IDX_W = $clog2(WAYS);

  // Commands from control to datapath: where each scan starts
  typedef struct packed {
    logic [IDX_W-1:0] rrStart;
    logic [IDX_W-1:0] rndStart;
  } scanCmd_t;

  // Result returned from datapath to control
  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } grant_t;
endpackage

// File: rtl/victim_ctrl.sv
module victim_ctrl
  import victim_pkg::*;
#(
  parameter int NUM_WAYS = victim_pkg::WAYS,
  parameter int LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] LFSR_POLY = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     allocStrobe,
  input  grant_t   grant,
  output scanCmd_t cmd
);
  localparam logic [IDX_W-1:0] LAST_WAY = IDX_W'(NUM_WAYS - 1);

  logic [IDX_W-1:0]  rrPtr;
  logic [LFSR_W-1:0] lfsr;

  // Pointer holds the last committed pick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= LAST_WAY;
    end else if (allocStrobe && grant.hit) begin
      rrPtr <= grant.idx;
    end
  end

  // Free-running Galois LFSR
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr <= LFSR_SEED;
    end else begin
      lfsr <= (lfsr >> 1) ^ (lfsr[0] ? LFSR_POLY : '0);
    end
  end

  always_comb begin
    cmd.rrStart  = (rrPtr == LAST_WAY) ? '0 : rrPtr + 1'b1;
    cmd.rndStart = IDX_W'(lfsr % LFSR_W'(NUM_WAYS));
  end
endmodule

// File: rtl/victim_datapath.sv
module victim_datapath
  import victim_pkg::*;
#(
  parameter int NUM_WAYS = victim_pkg::WAYS
) (
  input  logic                strategyRandom,
  input  logic                accessInstr,
  input  logic [NUM_WAYS-1:0] validBits,
  input  logic [NUM_WAYS-1:0] lineLockBits,
  input  logic [NUM_WAYS-1:0] dataWayLock,
  input  logic [NUM_WAYS-1:0] instrWayLock,
  input  scanCmd_t            cmd,
  output grant_t              grant
);
  logic [NUM_WAYS-1:0] eligible;
  logic [NUM_WAYS-1:0] freeVec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic maskBit;
    assign maskBit     = accessInstr ? instrWayLock[w] : dataWayLock[w];
    assign eligible[w] = ~(lineLockBits[w] | maskBit);
    assign freeVec[w]  = eligible[w] & ~validBits[w];
  end

  logic             freeHit;
  logic [IDX_W-1:0] freeIdx;

  // Lowest-numbered free eligible way
  always_comb begin
    freeHit = 1'b0;
    freeIdx = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (freeVec[i]) begin
        freeHit = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  logic [IDX_W-1:0] scanStart;
  logic             scanHit;
  logic [IDX_W-1:0] scanIdx;
  int               pos;

  assign scanStart = strategyRandom ? cmd.rndStart : cmd.rrStart;

  // First eligible way at or after scanStart, wrapping
  always_comb begin
    scanHit = 1'b0;
    scanIdx = '0;
    pos     = 0;
    for (int k = 0; k < NUM_WAYS; k++) begin
      pos = int'(scanStart) + k;
      if (pos >= NUM_WAYS) pos = pos - NUM_WAYS;
      if (!scanHit && eligible[pos]) begin
        scanHit = 1'b1;
        scanIdx = IDX_W'(pos);
      end
    end
  end

  always_comb begin
    if (freeHit) begin
      grant.hit = 1'b1;
      grant.idx = freeIdx;
    end else begin
      grant.hit = scanHit;
      grant.idx = scanHit ? scanIdx : '0;
    end
  end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
  import victim_pkg::*;
#(
  parameter int NUM_WAYS = victim_pkg::WAYS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                allocStrobe,
  input  logic                strategyRandom,
  input  logic                accessInstr,
  input  logic [NUM_WAYS-1:0] validBits,
  input  logic [NUM_WAYS-1:0] lineLockBits,
  input  logic [NUM_WAYS-1:0] dataWayLock,
  input  logic [NUM_WAYS-1:0] instrWayLock,
  output logic [NUM_WAYS-1:0] victimOneHot,
  output logic [IDX_W-1:0]    victimIdx,
  output logic                noVictim
);
  scanCmd_t cmd;
  grant_t   grant;

  victim_ctrl #(.NUM_WAYS(NUM_WAYS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocStrobe(allocStrobe),
    .grant      (grant),
    .cmd        (cmd)
  );

  victim_datapath #(.NUM_WAYS(NUM_WAYS)) u_dp (
    .strategyRandom(strategyRandom),
    .accessInstr   (accessInstr),
    .validBits     (validBits),
    .lineLockBits  (lineLockBits),
    .dataWayLock   (dataWayLock),
    .instrWayLock  (instrWayLock),
    .cmd           (cmd),
    .grant         (grant)
  );

  assign victimOneHot = grant.hit ? (NUM_WAYS'(1) << grant.idx) : '0;
  assign victimIdx    = grant.idx;
  assign noVictim     = ~grant.hit;
endmodule

// File: rtl/cache_victim_sel_checker.sv
module cache_victim_sel_checker
  import victim_pkg::*;
#(
  parameter int NUM_WAYS = victim_pkg::WAYS
) (
  input logic                clk,
  input logic                rstN,
  input logic                accessInstr,
  input logic [NUM_WAYS-1:0] validBits,
  input logic [NUM_WAYS-1:0] lineLockBits,
  input logic [NUM_WAYS-1:0] dataWayLock,
  input logic [NUM_WAYS-1:0] instrWayLock,
  input logic [NUM_WAYS-1:0] victimOneHot,
  input logic [IDX_W-1:0]    victimIdx,
  input logic                noVictim
);
  logic [NUM_WAYS-1:0] locks;
  assign locks = lineLockBits | (accessInstr ? instrWayLock : dataWayLock);

  AST_NO_LOCKED_PICK: assert property (@(posedge clk) disable iff (!rstN)
    (victimOneHot & locks) == '0);                                   // R1
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (|(~validBits & ~locks)) |-> ((victimOneHot & validBits) == '0)); // R2
  AST_NONE_IFF_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    noVictim == (&locks));                                           // R6
  AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    noVictim |-> (victimOneHot == '0 && victimIdx == '0));           // R6
  AST_ONEHOT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    !noVictim |-> ($onehot0(victimOneHot) && victimOneHot[victimIdx])); // R7
  AST_DIRECT_MAP: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(~locks) == 1) |-> (victimOneHot == ~locks));         // R8
endmodule

bind cache_victim_sel cache_victim_sel_checker #(.NUM_WAYS(NUM_WAYS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .accessInstr (accessInstr),
  .validBits   (validBits),
  .lineLockBits(lineLockBits),
  .dataWayLock (dataWayLock),
  .instrWayLock(instrWayLock),
  .victimOneHot(victimOneHot),
  .victimIdx   (victimIdx),
  .noVictim    (noVictim)
);

// File: tb/cache_victim_sel_bench.sv
module cache_victim_sel_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       allocStrobe = 1'b0;
  logic       strategyRandom = 1'b0;
  logic       accessInstr = 1'b0;
  logic [7:0] validBits = 8'hFF;
  logic [7:0] lineLockBits = 8'h00;
  logic [7:0] dataWayLock = 8'h00;
  logic [7:0] instrWayLock = 8'h00;
  logic [7:0] victimOneHot;
  logic [2:0] victimIdx;
  logic       noVictim;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cache_victim_sel u_cache_victim_sel (
    .clk(clk), .rstN(rstN), .allocStrobe(allocStrobe),
    .strategyRandom(strategyRandom), .accessInstr(accessInstr),
    .validBits(validBits), .lineLockBits(lineLockBits),
    .dataWayLock(dataWayLock), .instrWayLock(instrWayLock),
    .victimOneHot(victimOneHot), .victimIdx(victimIdx), .noVictim(noVictim)
  );

  // {strategy, instr, valid, lineLock, dataLock, instrLock, expIdx, expNone}
  localparam int NV = 11;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0}, // R3 scan from way 0
    {1'b0, 1'b0, 8'hF0, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0}, // R2 lowest free
    {1'b0, 1'b0, 8'hF3, 8'h04, 8'h00, 8'h00, 3'd3, 1'b0}, // R1 line lock skips free way
    {1'b0, 1'b0, 8'hFF, 8'h00, 8'h0F, 8'hF0, 3'd4, 1'b0}, // R9 data mask
    {1'b0, 1'b1, 8'hFF, 8'h00, 8'h0F, 8'hF0, 3'd0, 1'b0}, // R9 instr mask
    {1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h7F, 3'd7, 1'b0}, // R8 direct mapped
    {1'b1, 1'b0, 8'hFF, 8'h00, 8'hFE, 8'h00, 3'd0, 1'b0}, // R8 random direct
    {1'b0, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'h00, 3'd0, 1'b1}, // R6 all line locked
    {1'b0, 1'b0, 8'h7F, 8'h00, 8'h80, 8'h00, 3'd0, 1'b0}, // R1 way-locked free way
    {1'b1, 1'b0, 8'h00, 8'h00, 8'h01, 8'h00, 3'd1, 1'b0}, // R2 free beats random
    {1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 8'hFF, 3'd0, 1'b1}  // R9 instr mask all locked
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic checkPick(input string req, input int expIdx, input bit expNone);
    check({req, " idx"}, victimIdx, expIdx);
    check({req, " none"}, noVictim, expNone);
    check({req, " onehot"}, victimOneHot, expNone ? 0 : (1 << expIdx));
  endtask

  task automatic setIn(input bit s, input bit a, input logic [7:0] v,
                       input logic [7:0] l, input logic [7:0] d, input logic [7:0] i);
    @(negedge clk);
    strategyRandom = s; accessInstr = a; validBits = v;
    lineLockBits = l; dataWayLock = d; instrWayLock = i;
    #1;
  endtask

  task automatic strobe();
    @(negedge clk);
    allocStrobe = 1'b1;
    @(negedge clk);
    allocStrobe = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R4 reset state: pointer 7 so first full-set pick is way 0
    checkPick("R4 reset", 0, 1'b0);

    foreach (VEC[n]) begin
      setIn(VEC[n][37], VEC[n][36], VEC[n][35:28], VEC[n][27:20], VEC[n][19:12], VEC[n][11:4]);
      checkPick($sformatf("R1/R2/R3/R6/R8/R9 vec%0d", n), VEC[n][3:1], VEC[n][0]);
    end

    // R3/R4 round-robin walk with ways 1 and 5 locked, wrapping to 0
    setIn(1'b0, 1'b0, 8'hFF, 8'h00, 8'h22, 8'h00);
    checkPick("R3 walk start", 0, 1'b0);
    begin
      int seq[6] = '{2, 3, 4, 6, 7, 0};
      foreach (seq[k]) begin
        strobe();
        checkPick($sformatf("R3 R4 walk step%0d", k), seq[k], 1'b0);
      end
    end
    // pointer is now 7 (last pick); R4 no strobe -> hold
    @(negedge clk); #1;
    checkPick("R4 hold without strobe", 0, 1'b0);
    strobe(); // pointer 0
    strobe(); // pointer 2
    checkPick("R4 pointer after 2", 3, 1'b0);

    // R6 strobe while everything locked leaves pointer alone
    setIn(1'b0, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'h00);
    checkPick("R6 all locked", 0, 1'b1);
    strobe();
    strobe();
    setIn(1'b0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
    checkPick("R6 pointer unchanged", 3, 1'b0);

    // R5 random: eligible only, and spread across ways
    setIn(1'b1, 1'b0, 8'hFF, 8'h05, 8'h50, 8'h00);
    for (int c = 0; c < 32; c++) begin
      @(negedge clk); #1;
      check("R5 random eligible", ((victimOneHot & 8'h55) == 0 && !noVictim) ? 1 : 0, 1);
    end
    setIn(1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
    begin
      logic [7:0] seen = '0;
      for (int c = 0; c < 64; c++) begin
        @(negedge clk); #1;
        seen = seen | victimOneHot;
      end
      check("R5 distinct random ways >= 4", ($countones(seen) >= 4) ? 1 : 0, 1);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog got=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule